// File: doc/BRIEF.md
# Multi-Mode Prescaled Compare Timer

This block is a general-purpose interval timer. An up-counter advances once per prescaled tick. A compare register decides when the count has reached the programmed interval. When it does, a sticky time-out flag is set and an optional interrupt line is driven. Software picks one of four counting behaviours: single interval, repeating interval, repeating interval with a square-wave output, or free running.

Software controls the timer through a one-cycle write port with four word addresses:

| Address | Register |
|---|---|
| 0 | control: prescale, mode, run, interrupt enable, periodic compare-write select |
| 1 | compare value |
| 2 | status; a 1 in bit 0 clears the flag |
| 3 | counter reset; any data |

Starting and stopping reach the counter through a short synchroniser. A status output shows when the change has taken effect. A write to the compare register while the timer is running is resolved by the counting mode. In free-running mode the counter keeps counting past the match and wraps to zero after its all-ones value.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, time-out flag, interrupt, toggle output, run bit, active status and reset-busy output are all 0.
- R2: Control bits [7:0] hold the prescale value P, and the counter advances once every P+1 clock cycles while active (P = 0 means every cycle). A control write that changes P raises reset-busy, and on the next cycle both the prescaler and the count clear.
- R3: Control bits [9:8] select the mode: 0 one-shot, 1 periodic, 2 toggle, 3 continuous. In periodic mode, the tick that would bring the count to the compare value C sets the flag and returns the count to 0, so the period is C ticks.
- R4: The time-out flag stays set until a status write (address 2) with bit 0 = 1. A status write with bit 0 = 0 has no effect. A time-out in the same cycle as a clear leaves the flag set.
- R5: The interrupt output is high exactly when the flag is set and control bit 11 (interrupt enable) is 1.
- R6: In one-shot mode the time-out clears the run bit and stops counting at once, and the count is left at 0.
- R7: The run bit is control bit 10. The active output follows it two clock cycles later, and counting happens only while active. After a stop, restarting resumes from the held count.
- R8: Any write to address 3 raises reset-busy for one cycle. The count is 0 on the next cycle, whatever else happens that cycle.
- R9: In continuous mode, a match sets the flag while the count keeps advancing. A compare write (address 1) does not disturb the count.
- R10: In one-shot or toggle mode, a compare write clears the count to 0 and reloads the prescaler. The same applies in periodic mode when control bit 12 is 0.
- R11: In periodic mode with control bit 12 = 1, a compare write is resolved against the live count:
  - new value above the count: counting continues;
  - new value equal to the count: the flag is set and the count returns to 0;
  - new value below the count: the count returns to 0.
- R12: In toggle mode the toggle output inverts on every time-out, and counting otherwise follows periodic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | counting and register clock |
| rst_n | input | 1 | synchronous active-low reset |
| wr_en | input | 1 | register write strobe, one cycle |
| wr_addr | input | 2 | register word address |
| wr_data | input | DATA_W (24) | write data |
| count_o | output | CNT_W (24) | live counter value |
| tmo_flag_o | output | 1 | sticky time-out flag |
| irq_o | output | 1 | gated interrupt |
| toggle_o | output | 1 | toggle-mode square wave |
| run_o | output | 1 | run bit readback |
| active_o | output | 1 | counter actually enabled |
| rst_busy_o | output | 1 | counter reset in progress |

## Verification
The bench pins down the exact cycle of each event:
- the two-cycle start and stop latency, and the extra ticks that land while a stop propagates;
- the first tick after a prescale change;
- the one-shot self-stop, where a timer that relied on the synchroniser would count two more ticks;
- all three outcomes of a compare write in periodic-select mode, where a design that always restarts would lose the "continue" and "equal fires" cases;
- a clear and a time-out landing close together on the flag;
- a free-running compare write, which a wrong design would restart.

// File: rtl/timer_pkg.sv
// Shared encodings for the compare timer: mode codes, register addresses
// and control-word field positions. Assumes the prescale field fits in
// bits [7:0].
package timer_pkg;
    typedef enum logic [1:0] {
        MODE_ONCE   = 2'd0,
        MODE_PERIOD = 2'd1,
        MODE_TOGGLE = 2'd2,
        MODE_FREE   = 2'd3
    } tmr_mode_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CMP  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_CRST = 2'd3;

    localparam int F_MODE = 8;
    localparam int F_RUN  = 10;
    localparam int F_IEN  = 11;
    localparam int F_PSEL = 12;
endpackage

// File: rtl/tmr_prescaler.sv
// Divides the clock by (psc + 1) into a one-cycle tick while active.
// Assumes clr takes priority and restarts the division phase at zero.
module tmr_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;

    assign tick = active && (pcnt == psc);

    // Division counter: wraps on tick, holds while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (clr)    pcnt <= '0;
        else if (active) pcnt <= tick ? '0 : pcnt + PSC_W'(1);
    end
endmodule

// File: rtl/tmr_enable_sync.sv
// Delays the software run bit by STAGES cycles into the active enable.
// Assumes kill (hardware self-stop) must take effect on the same edge.
module tmr_enable_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kill,
    output logic active
);
    logic [STAGES-1:0] pipe;

    // Shift the run request through the delay line; kill flushes it.
    always_ff @(posedge clk) begin
        if (!rst_n)    pipe <= '0;
        else if (kill) pipe <= '0;
        else           pipe <= {pipe[STAGES-2:0], run};
    end

    assign active = pipe[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
// Up-counter with compare: advances on tick, detects the time-out and
// resolves compare-register writes according to the mode. Assumes the
// compare value is 2 or more and that clr wins over every other event.
module tmr_counter
    import timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_new,
    input  logic [CNT_W-1:0] cmp_cur,
    input  tmr_mode_e        mode,
    input  logic             cmp_sel,
    output logic [CNT_W-1:0] count,
    output logic             hit,
    output logic             restart
);
    logic [CNT_W-1:0] cmp_eff;
    logic [CNT_W-1:0] inc;
    logic             tick_hit;
    logic             sel_path;
    logic             wr_eq;
    logic             wr_lt;

    // Decode the match and the compare-write outcome for this cycle.
    always_comb begin
        cmp_eff  = cmp_wr ? cmp_new : cmp_cur;
        inc      = count + CNT_W'(1);
        tick_hit = tick && (inc == cmp_eff);
        sel_path = cmp_wr && cmp_sel && (mode == MODE_PERIOD);
        wr_eq    = sel_path && (cmp_new == count);
        wr_lt    = sel_path && (cmp_new < count);
        restart  = cmp_wr && (mode != MODE_FREE) && !sel_path;
        hit      = !clr && (wr_eq || (tick_hit && !restart && !wr_lt));
    end

    // Counter register: clear, write-resolved reset, or tick advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (clr)                        count <= '0;
        else if (restart || wr_eq || wr_lt)  count <= '0;
        else if (tick)                       count <= (tick_hit && mode != MODE_FREE) ? '0 : inc;
    end
endmodule

// File: rtl/cmp_timer.sv
// Top of the compare timer: register write decode, control state, the
// sticky flag, the toggle output and the interrupt gate. Assumes one
// write per cycle and a compare value of 2 or more.
module cmp_timer
    import timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int PSC_W  = 8,
    parameter int STAGES = 2,
    parameter int DATA_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              tmo_flag_o,
    output logic              irq_o,
    output logic              toggle_o,
    output logic              run_o,
    output logic              active_o,
    output logic              rst_busy_o
);
    localparam logic [CNT_W-1:0] CMP_RST = {CNT_W{1'b1}};

    logic [PSC_W-1:0] psc_q;
    tmr_mode_e        mode_q;
    logic             run_q, ien_q, psel_q;
    logic [CNT_W-1:0] cmp_q;
    logic             flag_q, tgl_q, busy_q;
    logic             ctrl_wr, cmp_wr, stat_wr, crst_wr, psc_chg;
    logic             tick, active, hit, restart, kill;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign cmp_wr  = wr_en && (wr_addr == A_CMP);
    assign stat_wr = wr_en && (wr_addr == A_STAT);
    assign crst_wr = wr_en && (wr_addr == A_CRST);
    assign psc_chg = ctrl_wr && (wr_data[PSC_W-1:0] != psc_q);
    assign kill    = hit && (mode_q == MODE_ONCE);

    // Control register; one-shot time-out clears the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q  <= '0;
            mode_q <= MODE_ONCE;
            run_q  <= 1'b0;
            ien_q  <= 1'b0;
            psel_q <= 1'b0;
        end else if (ctrl_wr) begin
            psc_q  <= wr_data[PSC_W-1:0];
            mode_q <= tmr_mode_e'(wr_data[F_MODE+1:F_MODE]);
            run_q  <= wr_data[F_RUN];
            ien_q  <= wr_data[F_IEN];
            psel_q <= wr_data[F_PSEL];
        end else if (kill) begin
            run_q  <= 1'b0;
        end
    end

    // Compare register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= CMP_RST;
        else if (cmp_wr) cmp_q <= wr_data[CNT_W-1:0];
    end

    // Counter-reset request: one cycle of busy, acted on next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= crst_wr || psc_chg;
    end

    // Sticky time-out flag; a new time-out beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_q <= 1'b0;
        else if (hit)                     flag_q <= 1'b1;
        else if (stat_wr && wr_data[0])   flag_q <= 1'b0;
    end

    // Toggle output inverts on each time-out in toggle mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                            tgl_q <= 1'b0;
        else if (hit && mode_q == MODE_TOGGLE) tgl_q <= ~tgl_q;
    end

    tmr_enable_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .run(run_q), .kill(kill), .active(active)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr(busy_q || restart),
        .active(active), .psc(psc_q), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(busy_q), .tick(tick),
        .cmp_wr(cmp_wr), .cmp_new(wr_data[CNT_W-1:0]), .cmp_cur(cmp_q),
        .mode(mode_q), .cmp_sel(psel_q),
        .count(count_o), .hit(hit), .restart(restart)
    );

    assign tmo_flag_o = flag_q;
    assign irq_o      = flag_q && ien_q;
    assign toggle_o   = tgl_q;
    assign run_o      = run_q;
    assign active_o   = active;
    assign rst_busy_o = busy_q;
endmodule

// File: rtl/cmp_timer_checker.sv
// Temporal checks on the compare timer, bound into every instance.
// Assumes the compare value is never written below 2.
module cmp_timer_checker
    import timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             wr_bit0,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic             run,
    input logic             active,
    input logic             busy,
    input logic             toggle,
    input logic             hit,
    input tmr_mode_e        mode
);
    // R8: the cycle after busy the count is zero.
    p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> count == '0);

    // R4: the flag holds until a clearing status write.
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(wr_en && wr_addr == A_STAT && wr_bit0) |=> flag);

    // R4: a time-out always leaves the flag set.
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R6: one-shot time-out stops the counter at once.
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit && mode == MODE_ONCE && !(wr_en && wr_addr == A_CTRL) |=> !run && !active);

    // R7: an inactive timer with no reset or compare write holds its count.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !busy && !(wr_en && (wr_addr == A_CMP || wr_addr == A_CRST)) |=> $stable(count));

    // R7: active only rises two cycles after the run bit was set.
    p_rise_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(run, 2));

    // R12: every toggle-mode time-out flips the toggle output.
    p_toggle_flip_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hit && mode == MODE_TOGGLE |=> toggle != $past(toggle));
endmodule

bind cmp_timer cmp_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit0(wr_data[0]), .count(count_o), .flag(tmo_flag_o), .run(run_o),
    .active(active_o), .busy(rst_busy_o), .toggle(toggle_o), .hit(hit),
    .mode(mode_q)
);

// File: tb/test_cmp_timer.sv
// Scoreboard bench: the driver queues expected values, and the monitor
// compares them at the following falling edge.
module test_cmp_timer;
    localparam int CW = 24;

    localparam int S_CNT  = 0;
    localparam int S_FLAG = 1;
    localparam int S_IRQ  = 2;
    localparam int S_TGL  = 3;
    localparam int S_RUN  = 4;
    localparam int S_ACT  = 5;
    localparam int S_BUSY = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] count_o;
    logic          tmo_flag_o, irq_o, toggle_o, run_o, active_o, rst_busy_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    typedef struct {
        int    sig;
        int    exp;
        string req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    cmp_timer i_cmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .tmo_flag_o(tmo_flag_o),
        .irq_o(irq_o), .toggle_o(toggle_o), .run_o(run_o),
        .active_o(active_o), .rst_busy_o(rst_busy_o)
    );

    function automatic int sample(int sig);
        case (sig)
            S_CNT:   return int'(count_o);
            S_FLAG:  return int'(tmo_flag_o);
            S_IRQ:   return int'(irq_o);
            S_TGL:   return int'(toggle_o);
            S_RUN:   return int'(run_o);
            S_ACT:   return int'(active_o);
            default: return int'(rst_busy_o);
        endcase
    endfunction

    function automatic logic [CW-1:0] ctrl(int psc, int mode, int run, int ien, int psel);
        return CW'(psc) | (CW'(mode) << 8) | (CW'(run) << 10) | (CW'(ien) << 11) | (CW'(psel) << 12);
    endfunction

    // Monitor: compare queued expectations at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t it;
                int   got;
                it  = sb.pop_front();
                got = sample(it.sig);
                vectors++;
                if (got != it.exp) begin
                    errors++;
                    $display("FAIL %s signal %0d: got %0d expected %0d", it.req, it.sig, got, it.exp);
                end
            end
        end
    end

    task automatic expect_v(int sig, int exp, string req);
        exp_t it;
        it.sig = sig;
        it.exp = exp;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic wt(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [CW-1:0] d);
        @(posedge clk);
        #1;
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        expect_v(S_CNT, 0, "R1"); expect_v(S_FLAG, 0, "R1"); expect_v(S_IRQ, 0, "R1");
        expect_v(S_TGL, 0, "R1"); expect_v(S_RUN, 0, "R1"); expect_v(S_ACT, 0, "R1");
        expect_v(S_BUSY, 0, "R1");
        wt(1);

        // R3 periodic, R7 start latency, R4 flag clear, R5 irq gate
        do_reset();
        wr(1, 5);
        wr(0, ctrl(0, 1, 1, 0, 0));
        expect_v(S_ACT, 0, "R7");
        wt(1); expect_v(S_ACT, 0, "R7");
        wt(1); expect_v(S_ACT, 1, "R7"); expect_v(S_CNT, 0, "R3");
        wt(4); expect_v(S_CNT, 4, "R3"); expect_v(S_FLAG, 0, "R3");
        wt(1); expect_v(S_CNT, 0, "R3"); expect_v(S_FLAG, 1, "R3"); expect_v(S_IRQ, 0, "R5");
        wr(2, 0); expect_v(S_FLAG, 1, "R4");
        wr(2, 1); expect_v(S_FLAG, 0, "R4");
        wt(1); expect_v(S_FLAG, 1, "R4");
        wr(0, ctrl(0, 1, 1, 1, 0)); expect_v(S_IRQ, 1, "R5");

        // R6 one-shot self stop
        do_reset();
        wr(1, 4);
        wr(0, ctrl(0, 0, 1, 0, 0));
        wt(5); expect_v(S_CNT, 3, "R6"); expect_v(S_FLAG, 0, "R6"); expect_v(S_ACT, 1, "R6");
        wt(1); expect_v(S_FLAG, 1, "R6"); expect_v(S_CNT, 0, "R6");
        expect_v(S_ACT, 0, "R6"); expect_v(S_RUN, 0, "R6");
        wt(4); expect_v(S_CNT, 0, "R6");

        // R7 stop and resume, then R8 counter reset write
        do_reset();
        wr(1, 100);
        wr(0, ctrl(0, 1, 1, 0, 0));
        wt(5);
        wr(0, ctrl(0, 1, 0, 0, 0));
        expect_v(S_ACT, 1, "R7"); expect_v(S_CNT, 5, "R7");
        wt(1); expect_v(S_ACT, 1, "R7");
        wt(1); expect_v(S_ACT, 0, "R7"); expect_v(S_CNT, 7, "R7");
        wt(4); expect_v(S_CNT, 7, "R7");
        wr(0, ctrl(0, 1, 1, 0, 0));
        wt(2); expect_v(S_CNT, 7, "R7"); expect_v(S_ACT, 1, "R7");
        wt(1); expect_v(S_CNT, 8, "R7");
        wr(3, 0); expect_v(S_BUSY, 1, "R8");
        wt(1); expect_v(S_BUSY, 0, "R8"); expect_v(S_CNT, 0, "R8");
        wt(1); expect_v(S_CNT, 1, "R8");

        // R2 prescale divide and prescale change
        do_reset();
        wr(1, 100);
        wr(0, ctrl(2, 1, 1, 0, 0)); expect_v(S_BUSY, 1, "R2");
        wt(4); expect_v(S_CNT, 0, "R2");
        wt(1); expect_v(S_CNT, 1, "R2");
        wt(2); expect_v(S_CNT, 1, "R2");
        wt(1); expect_v(S_CNT, 2, "R2");
        wr(0, ctrl(0, 1, 1, 0, 0)); expect_v(S_BUSY, 1, "R2"); expect_v(S_CNT, 2, "R2");
        wt(1); expect_v(S_CNT, 0, "R2");
        wt(1); expect_v(S_CNT, 1, "R2");

        // R9 continuous mode
        do_reset();
        wr(1, 3);
        wr(0, ctrl(0, 3, 1, 0, 0));
        wt(5); expect_v(S_CNT, 3, "R9"); expect_v(S_FLAG, 1, "R9");
        wt(1); expect_v(S_CNT, 4, "R9");
        wr(1, 50); expect_v(S_CNT, 6, "R9");

        // R10 compare write restarts
        do_reset();
        wr(1, 100);
        wr(0, ctrl(0, 1, 1, 0, 0));
        wt(5);
        wr(1, 40); expect_v(S_CNT, 0, "R10");
        wt(1); expect_v(S_CNT, 1, "R10");

        // R11 periodic-select compare writes
        do_reset();
        wr(1, 100);
        wr(0, ctrl(0, 1, 1, 0, 1));
        wt(5);
        wr(1, 60); expect_v(S_CNT, 5, "R11");
        wt(1); expect_v(S_CNT, 6, "R11"); expect_v(S_FLAG, 0, "R11");
        wr(1, 7); expect_v(S_CNT, 0, "R11"); expect_v(S_FLAG, 1, "R11");
        wt(3); expect_v(S_CNT, 3, "R11");
        wr(1, 2); expect_v(S_CNT, 0, "R11");
        wt(1); expect_v(S_CNT, 1, "R11");

        // R12 toggle output
        do_reset();
        wr(1, 3);
        wr(0, ctrl(0, 2, 1, 0, 0));
        wt(4); expect_v(S_TGL, 0, "R12");
        wt(1); expect_v(S_TGL, 1, "R12"); expect_v(S_CNT, 0, "R12");
        wt(3); expect_v(S_TGL, 0, "R12");

        wt(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule